// File: doc/BRIEF.md
# Flash Command Interface Sequencer

This block is the command front end of a behavioural flash memory model. A host issues byte-wide commands with a write strobe and an address. The block decodes them and drives a small word array held in registers. Reads, erase-verify and program-verify modes return array contents. Erase (of one sector or of the whole array) and program are destructive, so each needs two steps. A set-up command arms the operation, and the very next bus write must confirm it before anything in the array changes.

After a confirmed erase or program, a busy output stays high for a fixed, parameterised number of cycles. Any write the host makes during that window is dropped. Erased words read as all ones. Programming can only clear bits. The two verify commands pin the read port to a latched location and flag whether that word holds the value the last operation should have left there.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, busy is 0, mode is 0 (read), vfy_ok is 0 and every array word reads 0xFF.
- R2: In read mode (mode code 0), rdata equals the array word at addr, registered, one clock after addr is applied.
- R3: A write of 0x20 (mode becomes 1, erase armed) followed directly by a write of 0x20 at address a sets to 0xFF every word whose upper address bits (addr[AW-1:SECT_AW]) match those of a. All other words are unchanged.
- R4: A write of 0x20 followed directly by a write of 0x30 sets every array word to 0xFF.
- R5: While erase is armed, a write of any byte other than 0x20 or 0x30 returns mode to 0 and leaves the array unchanged.
- R6: A write of 0x40 (mode becomes 2, program armed) followed by a write carrying address a and data d sets word a to its old value AND d.
- R7: busy rises on the clock edge after a confirming write (an erase confirm, or the data write of a program) and stays high for exactly BUSY_CYC cycles.
- R8: Writes made while busy is high are ignored: mode and array contents do not change.
- R9: A write of 0xA0 at address a enters verify mode (mode code 3). From the next clock, rdata shows word a whatever addr is, and vfy_ok is 1 exactly when that word is 0xFF.
- R10: A write of 0xC0 at address a enters verify mode on word a, and vfy_ok is 1 exactly when that word equals the data byte of the last program write. That byte is 0xFF after reset.
- R11: In read or verify mode, 0x00 and 0xFF return mode to 0. Any byte that is not a recognised command leaves mode unchanged.
- R12: Once a program or erase has been confirmed, mode is 0 (read).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one write per cycle it is high |
| addr | input | AW | Host address for writes and reads |
| wdata | input | DW | Command or program data byte |
| rdata | output | DW | Registered array read data |
| busy | output | 1 | Operation in progress, writes dropped |
| mode | output | 2 | 0 read, 1 erase armed, 2 program armed, 3 verify |
| vfy_ok | output | 1 | Verify result for the latched location |

## Verification
Mode changes and array updates take effect on the edge that takes the write. busy rises on that same edge and falls BUSY_CYC edges later. rdata follows addr or the latched verify location one edge after the source is presented, and vfy_ok follows rdata with no added delay. The bench drives every input on the falling edge and samples on the next falling edge, so each write or address change has passed exactly one rising edge when it is checked. For busy, the bench counts falling edges from the confirming write and expects high for BUSY_CYC samples and low on the next one. A reference array kept in the bench predicts every read.

// File: rtl/flash_cmd_pkg.sv
// Package: shared mode encoding and command opcodes for the flash command sequencer.
// Assumes 8-bit command bytes; the mode encoding is visible at the top-level port.
package flash_cmd_pkg;
    typedef enum logic [1:0] {
        M_READ = 2'd0,
        M_ERA  = 2'd1,
        M_PRG  = 2'd2,
        M_VFY  = 2'd3
    } mode_t;

    localparam logic [7:0] OP_READ   = 8'h00;
    localparam logic [7:0] OP_ERA    = 8'h20;
    localparam logic [7:0] OP_BULK   = 8'h30;
    localparam logic [7:0] OP_PRG    = 8'h40;
    localparam logic [7:0] OP_EVFY   = 8'hA0;
    localparam logic [7:0] OP_PVFY   = 8'hC0;
    localparam logic [7:0] OP_RESET  = 8'hFF;
endpackage

// File: rtl/flash_busy_timer.sv
// Busy timer: on start, holds busy high for exactly BUSY_CYC cycles.
// Assumes start only arrives while busy is low (the decoder gates it).
module flash_busy_timer #(
    parameter int BUSY_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(BUSY_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(BUSY_CYC);

    logic [CW-1:0] cnt;

    // Load on start, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= LOAD;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    assert_busy_rises_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    assert_cnt_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LOAD);
endmodule

// File: rtl/flash_cmd_decode.sv
// Command decoder: tracks the mode, arms erase/program, and emits one-cycle
// operation strobes. Assumes one command per wr_en cycle; writes are dropped while busy.
module flash_cmd_decode
    import flash_cmd_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          busy,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output mode_t         state,
    output logic          era_go,
    output logic          era_bulk,
    output logic          prg_go,
    output logic [AW-1:0] vaddr,
    output logic          vkind_prg,
    output logic [DW-1:0] pexp
);
    logic  acc;
    logic  is_confirm;
    mode_t nxt;

    assign acc        = wr_en && !busy;
    assign is_confirm = (wdata[7:0] == OP_ERA) || (wdata[7:0] == OP_BULK);
    assign era_go     = acc && (state == M_ERA) && is_confirm;
    assign era_bulk   = (wdata[7:0] == OP_BULK);
    assign prg_go     = acc && (state == M_PRG);

    // Next-mode selection for an accepted write.
    always_comb begin
        nxt = state;
        if (acc) begin
            unique case (state)
                M_ERA, M_PRG: nxt = M_READ;
                default: begin
                    case (wdata[7:0])
                        OP_ERA:             nxt = M_ERA;
                        OP_PRG:             nxt = M_PRG;
                        OP_EVFY, OP_PVFY:   nxt = M_VFY;
                        OP_READ, OP_RESET:  nxt = M_READ;
                        default:            nxt = state;
                    endcase
                end
            endcase
        end
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= M_READ;
        else        state <= nxt;
    end

    // Verify location and kind, latched by a verify command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr     <= '0;
            vkind_prg <= 1'b0;
        end else if (acc && (state == M_READ || state == M_VFY) &&
                     (wdata[7:0] == OP_EVFY || wdata[7:0] == OP_PVFY)) begin
            vaddr     <= addr;
            vkind_prg <= (wdata[7:0] == OP_PVFY);
        end
    end

    // Expected program-verify value: data of the last program write.
    always_ff @(posedge clk) begin
        if (!rst_n)      pexp <= '1;
        else if (prg_go) pexp <= wdata;
    end

    assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> $stable(state));
    assert_abort_to_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == M_ERA && wr_en && !busy && wdata[7:0] != OP_ERA && wdata[7:0] != OP_BULK)
        |=> (state == M_READ));
    assert_read_after_op_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == M_PRG && wr_en && !busy) |=> (state == M_READ && busy));
endmodule

// File: rtl/flash_array.sv
// Behavioural flash array: erased words are all ones; erase clears a sector or
// the whole array to ones, program ANDs data in. Registered read port.
// Assumes era_go and prg_go are never high together.
module flash_array #(
    parameter int AW      = 4,
    parameter int DW      = 8,
    parameter int SECT_AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          era_go,
    input  logic          era_bulk,
    input  logic          prg_go,
    input  logic [AW-1:0] op_addr,
    input  logic [DW-1:0] op_data,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Array update: reset and erase to ones, program by AND.
    always_ff @(posedge clk) begin
        for (int w = 0; w < DEPTH; w++) begin
            if (!rst_n)
                mem[w] <= '1;
            else if (era_go && (era_bulk || ((AW'(w) >> SECT_AW) == (op_addr >> SECT_AW))))
                mem[w] <= '1;
            else if (prg_go && (AW'(w) == op_addr))
                mem[w] <= mem[w] & op_data;
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '1;
        else        rdata <= mem[raddr];
    end

    // Checker state: the last operation, for the properties below.
    logic          prg_q, era_q;
    logic [AW-1:0] a_q;
    logic [DW-1:0] old_q, d_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prg_q <= 1'b0; era_q <= 1'b0; a_q <= '0; old_q <= '0; d_q <= '0;
        end else begin
            prg_q <= prg_go; era_q <= era_go; a_q <= op_addr;
            old_q <= mem[op_addr]; d_q <= op_data;
        end
    end

    assert_program_and_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prg_q |-> (mem[a_q] == (old_q & d_q)));
    assert_erase_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        era_q |-> (mem[a_q] == '1));
endmodule

// File: rtl/flash_cmd_seq.sv
// Top: flash command sequencer. Connects the decoder, busy timer and array,
// steers the read address in verify mode and forms the verify flag.
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int AW       = 4,
    parameter int DW       = 8,
    parameter int SECT_AW  = 2,
    parameter int BUSY_CYC = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          busy,
    output logic [1:0]    mode,
    output logic          vfy_ok
);
    mode_t         state;
    logic          era_go, era_bulk, prg_go, vkind_prg;
    logic [AW-1:0] vaddr, raddr;
    logic [DW-1:0] pexp;

    flash_cmd_decode #(.AW(AW), .DW(DW)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy),
        .addr(addr), .wdata(wdata), .state(state),
        .era_go(era_go), .era_bulk(era_bulk), .prg_go(prg_go),
        .vaddr(vaddr), .vkind_prg(vkind_prg), .pexp(pexp)
    );

    flash_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(era_go || prg_go), .busy(busy)
    );

    flash_array #(.AW(AW), .DW(DW), .SECT_AW(SECT_AW)) u_arr (
        .clk(clk), .rst_n(rst_n), .era_go(era_go), .era_bulk(era_bulk),
        .prg_go(prg_go), .op_addr(addr), .op_data(wdata),
        .raddr(raddr), .rdata(rdata)
    );

    // Verify mode pins the read port to the latched location.
    assign raddr  = (state == M_VFY) ? vaddr : addr;
    assign mode   = state;
    // Verify flag: erased check or match against the last program data.
    assign vfy_ok = (state == M_VFY) && (vkind_prg ? (rdata == pexp) : (rdata == '1));

    assert_one_op_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(era_go && prg_go));
    assert_no_op_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(era_go || prg_go));
endmodule

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;
    localparam int AW = 4, DW = 8, SECT_AW = 2, BUSY = 6;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic busy, vfy_ok;
    logic [1:0] mode;

    int checks = 0, errors = 0;
    logic [DW-1:0] ref_mem [DEPTH];
    logic [DW-1:0] ref_pexp;

    always #4 clk = ~clk;

    flash_cmd_seq #(.AW(AW), .DW(DW), .SECT_AW(SECT_AW), .BUSY_CYC(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .busy(busy), .mode(mode), .vfy_ok(vfy_ok)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string r, input logic [AW-1:0] a);
        @(negedge clk);
        addr = a;
        @(negedge clk);
        chk(r, rdata, ref_mem[a]);
    endtask

    task automatic rd_all(input string r);
        for (int i = 0; i < DEPTH; i++) rd(r, AW'(i));
    endtask

    task automatic wait_busy(input string r);
        for (int i = 0; i < BUSY; i++) begin
            chk(r, busy, 1'b1);
            @(negedge clk);
        end
        chk(r, busy, 1'b0);
    endtask

    function automatic logic [DW-1:0] prog_val(input logic [DW-1:0] o, input logic [DW-1:0] d);
        return o & d;
    endfunction

    task automatic do_prog(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr(a, 8'h40);
        chk("R6 armed", mode, 2'd2);
        wr(a, d);
        ref_mem[a] = prog_val(ref_mem[a], d);
        ref_pexp = d;
        chk("R12 mode", mode, 2'd0);
        wait_busy("R7 program busy");
    endtask

    task automatic do_erase(input logic [AW-1:0] a, input logic bulk);
        wr(a, 8'h20);
        chk("R3 armed", mode, 2'd1);
        wr(a, bulk ? 8'h30 : 8'h20);
        for (int i = 0; i < DEPTH; i++)
            if (bulk || ((AW'(i) >> SECT_AW) == (a >> SECT_AW))) ref_mem[i] = '1;
        chk("R12 mode", mode, 2'd0);
        wait_busy(bulk ? "R4 busy" : "R3 busy");
    endtask

    task automatic do_verify(input logic [AW-1:0] a, input logic kind_prg);
        wr(a, kind_prg ? 8'hC0 : 8'hA0);
        addr = a + 1'b1;
        @(negedge clk);
        chk("R9 mode", mode, 2'd3);
        chk(kind_prg ? "R10 rdata" : "R9 rdata", rdata, ref_mem[a]);
        chk(kind_prg ? "R10 flag" : "R9 flag", vfy_ok,
            kind_prg ? (ref_mem[a] == ref_pexp) : (ref_mem[a] == 8'hFF));
        wr(a, 8'h00);
        chk("R11 exit verify", mode, 2'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'h5A17;
        void'($urandom(seed));
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '1;
        ref_pexp = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 1'b0);
        chk("R1 mode", mode, 2'd0);
        chk("R1 vfy_ok", vfy_ok, 1'b0);
        rd_all("R1 erased array");

        // Directed: program, R2 reads
        do_prog(4'd5, 8'h3C);
        do_prog(4'd5, 8'hF0);
        do_prog(4'd9, 8'hA5);
        rd_all("R2 read after program");

        // R8: writes during busy ignored
        wr(4'd2, 8'h40);
        wr(4'd2, 8'h0F);
        ref_mem[2] = prog_val(ref_mem[2], 8'h0F); ref_pexp = 8'h0F;
        wr(4'd2, 8'h20);
        wr(4'd3, 8'h20);
        repeat (BUSY) @(negedge clk);
        chk("R8 mode after busy", mode, 2'd0);
        rd_all("R8 array after busy writes");

        // R5: abort erase
        wr(4'd5, 8'h20);
        wr(4'd5, 8'h40);
        chk("R5 aborted mode", mode, 2'd0);
        chk("R5 no busy", busy, 1'b0);
        rd_all("R5 array unchanged");

        // R11: unknown opcode and reset
        wr(4'd0, 8'h55);
        chk("R11 unknown ignored", mode, 2'd0);
        wr(4'd0, 8'h40);
        wr(4'd0, 8'hFF);   // data 0xFF programs, no change to bits
        chk("R11 prg data FF", mode, 2'd0);
        ref_pexp = 8'hFF;
        wait_busy("R7 busy FF data");
        wr(4'd0, 8'hA0);
        wr(4'd0, 8'h77);
        chk("R11 unknown in verify", mode, 2'd3);
        wr(4'd0, 8'hFF);
        chk("R11 reset to read", mode, 2'd0);

        // Verify modes
        do_verify(4'd5, 1'b0);
        do_verify(4'd7, 1'b0);
        do_prog(4'd7, 8'h81);
        do_verify(4'd7, 1'b1);
        do_prog(4'd5, 8'hFF);
        do_verify(4'd5, 1'b1);

        // Sector and bulk erase
        do_erase(4'd6, 1'b0);
        rd_all("R3 sector erase");
        do_prog(4'd12, 8'h00);
        do_prog(4'd1, 8'h11);
        do_erase(4'd0, 1'b1);
        rd_all("R4 bulk erase");

        // Constrained random mix
        for (int n = 0; n < 300; n++) begin
            int unsigned sel;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            sel = $urandom_range(0, 9);
            a = AW'($urandom_range(0, DEPTH - 1));
            d = DW'($urandom);
            case (sel)
                0, 1, 2, 3: do_prog(a, d);
                4:          do_erase(a, 1'b0);
                5:          if ($urandom_range(0, 4) == 0) do_erase(a, 1'b1);
                            else rd("R2 random read", a);
                6:          do_verify(a, 1'b0);
                7:          do_verify(a, 1'b1);
                8: begin
                    wr(a, 8'h20);
                    wr(a, (d == 8'h20 || d == 8'h30) ? 8'h00 : d);
                    chk("R5 random abort", mode, 2'd0);
                end
                default:    rd("R2 random read", a);
            endcase
        end
        rd_all("R2 final array");

        summary();
        $finish;
    end
endmodule